// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block holds two periodic timers that run independently of each other. Each one is a two-stage down-counter: a prescaler stage that wraps every `P+1` clock cycles and a divider stage that steps once per prescaler wrap. When both stages are at zero on the same cycle, the timer raises a single-cycle expiry pulse, reloads both stages from their programmed values and runs again without further software action. The period of a timer is therefore `(P+1)*(D+1)` clock cycles.

Software programs the four reload values through a simple 16-bit write port. Any write to a timer's prescaler or divider reloads and restarts that timer at once. The live down-count of every stage can be read back through a separate combinational read port at its own read-only addresses. A timer whose two reload values are both zero stands still. After reset the reload values are 0xFFFF and the live counts are zero. The timers stay idle until software first writes to them.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both timers are idle: no expiry pulse appears and every live count reads 0 until the first write to that timer.
- R2: After a write, an expiry pulse appears on the timer's output exactly N=(P+1)*(D+1) cycles after the edge that captured the write, where P and D are the prescaler and divider reload values.
- R3: Each expiry pulse is one cycle wide. The timer then repeats with period N with no further writes.
- R4: The prescaler counts down once per cycle and wraps to its reload value after 0. The divider decrements only on a prescaler wrap. Reads at byte address 0x36 and 0x38 return timer 0 live prescaler and divider counts. Reads at 0x3A and 0x3C return the same two counts for timer 1.
- R5: Writes at byte address 0x00 and 0x02 set timer 0 prescaler and divider reloads. Writes at 0x04 and 0x06 set the same two reloads for timer 1. Each such write restarts that timer from the new values.
- R6: A timer whose prescaler and divider reloads are both zero is stopped: no pulses, and its live counts read 0.
- R7: A write to a timer on the same edge at which it would expire takes priority: no pulse is issued, and the timer restarts.
- R8: A write to one timer has no effect on the other timer's counts or pulses.
- R9: The reset reload values are 0xFFFF. Writing only the timer 0 divider with 0 after reset gives a period of 65536 cycles.
- R10: Writes to any other address are ignored. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe, captured on the rising edge |
| wrAddr | input | 8 | Byte address of the write |
| wrData | input | 16 | Reload value being written |
| rdAddr | input | 8 | Byte address of the read |
| rdData | output | 16 | Live count at rdAddr (combinational), 0 when unmapped |
| expiry | output | 2 | One-cycle expiry pulse per timer, bit i for timer i |

## Verification
The bench builds the block with its defaults: two timers with 16-bit stages and 8-bit addresses. With these defaults the 0xFFFF reset reload can be observed directly. A divider-only write yields a 65536-cycle period, and the bench waits out that period in full while the second timer goes through short periods, a stop, and a write that coincides with its expiry. The reference model derives the expected live counts arithmetically from the cycles elapsed since the last restart, so every readback address is compared on every cycle.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  parameter int CNT_W = 16;

  // one write command per channel, produced by the control decoder
  typedef struct packed {
    logic             loadPre;
    logic             loadDiv;
    logic [CNT_W-1:0] value;
  } chanCmd_t;
endpackage

// File: rtl/dpt_ctrl.sv
module dpt_ctrl
  import dpt_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 8,
  parameter int WR_BASE    = 'h00,
  parameter int RD_BASE    = 'h36
) (
  input  logic                                  wrEn,
  input  logic [ADDR_W-1:0]                     wrAddr,
  input  logic [CNT_W-1:0]                      wrData,
  input  logic [ADDR_W-1:0]                     rdAddr,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]      preCnt,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]      divCnt,
  output chanCmd_t [NUM_TIMERS-1:0]             cmd,
  output logic [CNT_W-1:0]                      rdData
);
  localparam int STRIDE = 4;
  localparam int STAGE  = 2;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] PRE_WA = ADDR_W'(WR_BASE + STRIDE*i);
    localparam logic [ADDR_W-1:0] DIV_WA = ADDR_W'(WR_BASE + STRIDE*i + STAGE);
    assign cmd[i].loadPre = wrEn && (wrAddr == PRE_WA);
    assign cmd[i].loadDiv = wrEn && (wrAddr == DIV_WA);
    assign cmd[i].value   = wrData;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (rdAddr == ADDR_W'(RD_BASE + STRIDE*i))         rdData = preCnt[i];
      if (rdAddr == ADDR_W'(RD_BASE + STRIDE*i + STAGE)) rdData = divCnt[i];
    end
  end
endmodule

// File: rtl/dpt_datapath.sv
module dpt_datapath
  import dpt_pkg::*;
#(
  parameter int NUM_TIMERS = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  chanCmd_t [NUM_TIMERS-1:0]         cmd,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0]  preCnt,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0]  divCnt,
  output logic [NUM_TIMERS-1:0]             expiry
);
  localparam logic [CNT_W-1:0] RELOAD_RST = '1;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
    logic [CNT_W-1:0] preRel, divRel;
    logic [CNT_W-1:0] newPre, newDiv;
    logic             running;
    logic             load;

    assign load   = cmd[i].loadPre || cmd[i].loadDiv;
    assign newPre = cmd[i].loadPre ? cmd[i].value : preRel;
    assign newDiv = cmd[i].loadDiv ? cmd[i].value : divRel;

    always_ff @(posedge clk) begin
      if (rst) begin
        preRel    <= RELOAD_RST;
        divRel    <= RELOAD_RST;
        preCnt[i] <= '0;
        divCnt[i] <= '0;
        running   <= 1'b0;
        expiry[i] <= 1'b0;
      end else if (load) begin
        preRel    <= newPre;
        divRel    <= newDiv;
        preCnt[i] <= newPre;
        divCnt[i] <= newDiv;
        running   <= |{newPre, newDiv};
        expiry[i] <= 1'b0;
      end else if (running) begin
        if (preCnt[i] == '0) begin
          preCnt[i] <= preRel;
          if (divCnt[i] == '0) begin
            divCnt[i] <= divRel;
            expiry[i] <= 1'b1;
          end else begin
            divCnt[i] <= divCnt[i] - 1'b1;
            expiry[i] <= 1'b0;
          end
        end else begin
          preCnt[i] <= preCnt[i] - 1'b1;
          expiry[i] <= 1'b0;
        end
      end else begin
        expiry[i] <= 1'b0;
      end
    end

    // R3: a pulse never lasts two cycles
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
      expiry[i] |=> !expiry[i]);
    // R6: an idle channel stays silent
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !running |=> !expiry[i]);
    // R7: a write edge never yields a pulse
    p_load_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      load |=> !expiry[i]);
    // R4: divider moves only when the prescaler wraps
    p_div_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (running && !load && preCnt[i] != '0) |=> $stable(divCnt[i]));
    // R2: the pulse coincides with both stages back at their reload values
    p_expiry_reload_r2: assert property (@(posedge clk) disable iff (rst)
      expiry[i] |-> (preCnt[i] == preRel && divCnt[i] == divRel));
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dpt_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CNT_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [CNT_W-1:0]      rdData,
  output logic [NUM_TIMERS-1:0] expiry
);
  chanCmd_t [NUM_TIMERS-1:0]         cmd;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  preCnt;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  divCnt;

  dpt_ctrl #(
    .NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W), .WR_BASE('h00), .RD_BASE('h36)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .preCnt(preCnt), .divCnt(divCnt), .cmd(cmd), .rdData(rdData)
  );

  dpt_datapath #(.NUM_TIMERS(NUM_TIMERS)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd),
    .preCnt(preCnt), .divCnt(divCnt), .expiry(expiry)
  );
endmodule

// File: tb/tb_dual_interval_timer.sv
`timescale 1ns/1ps
module tb_dual_interval_timer;
  logic        clk = 0;
  logic        rst = 1;
  logic        wrEn = 0;
  logic [7:0]  wrAddr = 0;
  logic [15:0] wrData = 0;
  logic [7:0]  rdAddr = 8'h36;
  logic [15:0] rdData;
  logic [1:0]  expiry;

  int checks = 0, errors = 0, cyc = 0;
  int cnt0 = 0, cnt1 = 0;

  dual_interval_timer dut (.clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .expiry(expiry));

  always #2.5 clk = ~clk;

  // reference model: reload values, run flag, cycles elapsed since restart
  int  mP[2], mD[2], mE[2];
  bit  mRun[2], mPulse[2];

  function automatic int expCount(int t, bit wantDiv);
    if (!mRun[t]) return 0;
    if (wantDiv) return mD[t] - mE[t] / (mP[t] + 1);
    return mP[t] - mE[t] % (mP[t] + 1);
  endfunction

  always @(posedge clk) begin
    cyc++;
    for (int t = 0; t < 2; t++) begin
      mPulse[t] = 0;
      if (rst) begin
        mP[t] = 'hFFFF; mD[t] = 'hFFFF; mE[t] = 0; mRun[t] = 0;
      end else if (wrEn && (wrAddr == 8'(4*t) || wrAddr == 8'(4*t+2))) begin
        if (wrAddr == 8'(4*t)) mP[t] = int'(wrData); else mD[t] = int'(wrData);
        mE[t] = 0;
        mRun[t] = (mP[t] != 0) || (mD[t] != 0);
      end else if (mRun[t]) begin
        mE[t]++;
        if (mE[t] == (mP[t] + 1) * (mD[t] + 1)) begin
          mE[t] = 0; mPulse[t] = 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // rotating read address: four live counts plus one unmapped address
  int rdSel = 0;
  always @(posedge clk) begin
    #1;
    rdSel = (rdSel + 1) % 5;
    case (rdSel)
      0: rdAddr = 8'h36;
      1: rdAddr = 8'h38;
      2: rdAddr = 8'h3A;
      3: rdAddr = 8'h3C;
      default: rdAddr = 8'h10;
    endcase
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (expiry[0]) cnt0++;
      if (expiry[1]) cnt1++;
      chk("R2 expiry timer0", int'(expiry[0]), int'(mPulse[0]));
      chk("R2 expiry timer1", int'(expiry[1]), int'(mPulse[1]));
      case (rdAddr)
        8'h36: chk("R4 read timer0 prescaler", int'(rdData), expCount(0, 0));
        8'h38: chk("R4 read timer0 divider",   int'(rdData), expCount(0, 1));
        8'h3A: chk("R4 read timer1 prescaler", int'(rdData), expCount(1, 0));
        8'h3C: chk("R4 read timer1 divider",   int'(rdData), expCount(1, 1));
        default: chk("R10 unmapped read", int'(rdData), 0);
      endcase
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 0;
  endtask

  int c, c0, wr0;
  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    repeat (20) @(posedge clk);
    #1;
    chk("R1 no pulses while idle after reset", cnt0 + cnt1, 0);

    // R9: divider-only write keeps the 0xFFFF prescaler reload
    doWrite(8'h02, 16'h0000);
    wr0 = cyc;

    // R5: timer1 reload P=2 D=3, N=12
    doWrite(8'h04, 16'd2);
    doWrite(8'h06, 16'd3);
    repeat (11) @(posedge clk);
    #1;
    chk("R5 no pulse before N cycles", int'(expiry[1]), 0);
    @(posedge clk);
    #1;
    chk("R5 first pulse N cycles after write", int'(expiry[1]), 1);

    // R3: periodic repetition, 10 pulses in 120 cycles
    c = cnt1;
    repeat (120) @(posedge clk);
    #1;
    chk("R3 pulses in 120 cycles", cnt1 - c, 10);

    // R7: write lands on the expiry edge
    repeat (11) @(posedge clk);
    #1;
    doWrite(8'h06, 16'd3);
    #1;
    chk("R7 write on expiry edge suppresses pulse", int'(expiry[1]), 0);

    // R6: both reloads zero stops timer1
    doWrite(8'h04, 16'd0);
    doWrite(8'h06, 16'd0);
    c = cnt1;
    repeat (50) @(posedge clk);
    #1;
    chk("R6 stopped timer is silent", cnt1 - c, 0);

    // R10: writes to unmapped or read-only addresses change nothing
    doWrite(8'h08, 16'd5);
    doWrite(8'h36, 16'd7);
    doWrite(8'h3C, 16'd9);
    repeat (20) @(posedge clk);
    #1;
    chk("R10 ignored writes leave timer1 stopped", cnt1 - c, 0);

    // timer1 running N=4 while timer0 finishes its long period
    doWrite(8'h04, 16'd1);
    doWrite(8'h06, 16'd1);

    while (cyc < wr0 + 65535) begin
      @(posedge clk);
      #1;
    end
    chk("R9 no timer0 pulse before 65536 cycles", cnt0, 0);
    @(posedge clk);
    #1;
    chk("R9 timer0 pulse at 65536 cycles", int'(expiry[0]), 1);

    // R8: restarting timer0 leaves timer1 undisturbed
    c = cnt1;
    doWrite(8'h00, 16'd1);
    doWrite(8'h02, 16'd2);
    repeat (38) @(posedge clk);
    #1;
    chk("R8 timer1 pulses across timer0 writes", cnt1 - c, 10);
    c0 = cnt0;
    repeat (42) @(posedge clk);
    #1;
    chk("R8 timer0 new period 6", cnt0 - c0, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule